// File: doc/BRIEF.md
# GPIO Port Register Bank

This block holds the control and data registers for four 8-bit general-purpose I/O ports, plus two pin-function select registers. A processor reaches them through a simple synchronous byte bus. Each request carries an offset, read and write strobes, a size code and write data. The response comes back one cycle later as registered read data and a single-cycle error flag.

Each port has four registers: output data, output mode, direction and pin input. The offset map is sparse and fixed. Several registers accept only some of their bits. A write that sets a bit outside its writable field is refused as a whole.

The output data and direction registers drive the port's data and output-enable buses directly. The pin-input registers show the external port inputs after a two-stage synchronizer. Pad electronics and alternate-function routing live outside the block.

Top module: `gpio_regbank`

## Requirements
- R1: After reset, every output, mode and direction register reads 0x00, except the port 2 mode register, which reads 0xFF. Select register A reads 0x00 and select register B reads 0x0F. `port_out` and `port_oe` are all zero.
- R2: The registers sit at these offsets:
  - Output data for ports 0, 1, 2 and 3: 0x00, 0x01, 0x04, 0x05.
  - Mode: 0x20, 0x21, 0x24, 0x25.
  - Direction: 0x60, 0x61, 0x64, 0x65.
  - Pin input: 0x80, 0x81, 0x84, 0x85.
  - Select A: 0x44. Select B: 0x48.
  - An accepted write is returned unchanged by a later read of the same offset.
- R3: A read or write to any other offset raises `bus_err`, returns read data 0x00 and changes no register.
- R4: Only `bus_size` = 0 (one byte) is legal. Codes 1 (two bytes), 2 (four bytes) and 3 (reserved) raise `bus_err` and change nothing.
- R5: For port 3, the output, mode and direction registers have writable mask 0x03. A write with any of bits 7:2 set is refused with `bus_err`, and the register keeps its value.
- R6: For ports 0 and 1, the mode register has writable mask 0x01. A write with any of bits 7:1 set is refused with `bus_err`.
- R7: Any write to a pin-input register is refused with `bus_err`. A read of a pin-input register returns that port's `port_in` byte once the input has been stable for at least three clock edges.
- R8: Select register A has writable mask 0x03 and select register B has mask 0x0F. A write outside the mask is refused with `bus_err`.
- R9: `bus_rdata` and `bus_err` are registered and valid in the cycle after the strobe. `bus_err` stays high for exactly one cycle per failing request. `bus_rdata` is 0x00 for writes and for failed requests.
- R10: `port_out` byte n equals port n's output register and `port_oe` byte n equals its direction register. Both change only in the cycle after an accepted write.
- R11: A request with both `bus_rd` and `bus_wr` high raises `bus_err` and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the request |
| bus_rd | input | 1 | Read strobe, one cycle per request |
| bus_wr | input | 1 | Write strobe, one cycle per request |
| bus_size | input | 2 | Access size code; 0 is one byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_err | output | 1 | One-cycle error response |
| port_in | input | 32 | External port inputs, byte n = port n |
| port_out | output | 32 | Output data, byte n = port n |
| port_oe | output | 32 | Per-bit output enable, byte n = port n |

## Verification
A register corrupted by a refused or misdecoded write shows up on `port_out` or `port_oe` at the very next negative edge, for the output and direction registers. The mode and select registers show a fault only when they are next read back. For this reason the random phase reads every offset often and compares each value against a bench model. A decoder fault becomes visible one cycle after the request, either as a wrong error flag or as nonzero data on a refused read. Synchronizer faults show up as stale pin reads taken three edges after the inputs change.

// File: rtl/gpio_regbank_pkg.sv
// Shared types and writable-mask rules for the GPIO register bank.
// Assumes byte-wide registers and four ports at fixed offsets.
package gpio_regbank_pkg;

    localparam int BYTE_W  = 8;
    localparam int NPORTS  = 4;
    localparam int PIDX_W  = $clog2(NPORTS);

    typedef enum logic [2:0] {
        K_NONE,
        K_OUT,
        K_MODE,
        K_DIR,
        K_PIN,
        K_SELA,
        K_SELB
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e         kind;
        logic [PIDX_W-1:0] port;
    } reg_sel_t;

    // Bits a write may set for a given register; zero for read-only or unmapped.
    function automatic logic [BYTE_W-1:0] wr_mask(reg_kind_e k, logic [PIDX_W-1:0] p);
        logic [BYTE_W-1:0] m;
        unique case (k)
            K_OUT, K_DIR: m = (p == 2'd3) ? 8'h03 : 8'hFF;
            K_MODE:       m = (p == 2'd3) ? 8'h03 : ((p <= 2'd1) ? 8'h01 : 8'hFF);
            K_SELA:       m = 8'h03;
            K_SELB:       m = 8'h0F;
            default:      m = 8'h00;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
// Offset decoder: maps a byte offset to a register kind and port index.
// Purely combinational; offsets outside the map give K_NONE.
module gpio_addr_dec
    import gpio_regbank_pkg::*;
(
    input  logic [7:0] addr,
    output reg_sel_t   sel
);

    // Decode the port group from the upper bits and the port from bits 2 and 0.
    always_comb begin
        sel.kind = K_NONE;
        sel.port = {addr[2], addr[0]};
        if (addr[4:3] == 2'b00 && addr[1] == 1'b0) begin
            unique case (addr[7:5])
                3'd0:    sel.kind = K_OUT;
                3'd1:    sel.kind = K_MODE;
                3'd3:    sel.kind = K_DIR;
                3'd4:    sel.kind = K_PIN;
                default: sel.kind = K_NONE;
            endcase
        end
        if (addr == 8'h44) sel.kind = K_SELA;
        if (addr == 8'h48) sel.kind = K_SELB;
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Multi-stage synchronizer for the asynchronous port inputs.
// Assumes each bit is sampled independently; no bus coherency implied.
module gpio_in_sync #(
    parameter int WIDTH       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg [SYNC_STAGES];

    // Shift the inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[SYNC_STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
// Output, mode and direction registers for one port.
// Write enables arrive already qualified (decode, size and mask checks passed).
module gpio_port_regs
    import gpio_regbank_pkg::*;
#(
    parameter int PORT_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_out,
    input  logic              we_mode,
    input  logic              we_dir,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] out_q,
    output logic [BYTE_W-1:0] mode_q,
    output logic [BYTE_W-1:0] dir_q
);

    localparam logic [BYTE_W-1:0] MODE_RST = (PORT_IDX == 2) ? 8'hFF : 8'h00;
    localparam logic [PIDX_W-1:0] PID      = PIDX_W'(PORT_IDX);

    // Hold the three port registers, loading whichever one is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            mode_q <= MODE_RST;
            dir_q  <= '0;
        end else begin
            if (we_out)  out_q  <= wdata;
            if (we_mode) mode_q <= wdata;
            if (we_dir)  dir_q  <= wdata;
        end
    end

    // R5
    out_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q & ~wr_mask(K_OUT, PID)) == '0);
    // R6
    mode_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q & ~wr_mask(K_MODE, PID)) == '0);
    // R5
    dir_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q & ~wr_mask(K_DIR, PID)) == '0);

endmodule

// File: rtl/gpio_regbank.sv
// Top of the GPIO register bank: bus decode, legality checks, register
// storage, pin synchronizers and a registered one-cycle response.
// Assumes a single outstanding request per cycle on the byte bus.
module gpio_regbank
    import gpio_regbank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               bus_addr,
    input  logic                     bus_rd,
    input  logic                     bus_wr,
    input  logic [1:0]               bus_size,
    input  logic [BYTE_W-1:0]        bus_wdata,
    output logic [BYTE_W-1:0]        bus_rdata,
    output logic                     bus_err,
    input  logic [NPORTS*BYTE_W-1:0] port_in,
    output logic [NPORTS*BYTE_W-1:0] port_out,
    output logic [NPORTS*BYTE_W-1:0] port_oe
);

    localparam logic [1:0] SZ_BYTE = 2'd0;

    reg_sel_t               sel;
    logic [BYTE_W-1:0]      mask;
    logic                   acc_err;
    logic                   wr_ok;
    logic [BYTE_W-1:0]      rd_val;
    logic [BYTE_W-1:0]      sel_a_q;
    logic [BYTE_W-1:0]      sel_b_q;
    logic [NPORTS*BYTE_W-1:0] pin_sync;
    logic [BYTE_W-1:0]      out_arr  [NPORTS];
    logic [BYTE_W-1:0]      mode_arr [NPORTS];
    logic [BYTE_W-1:0]      dir_arr  [NPORTS];

    gpio_addr_dec i_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_in_sync #(
        .WIDTH       (NPORTS*BYTE_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (port_in),
        .dout  (pin_sync)
    );

    assign mask = wr_mask(sel.kind, sel.port);

    // Classify the current request as legal or failing.
    always_comb begin
        acc_err = 1'b0;
        if (bus_rd || bus_wr) begin
            if (sel.kind == K_NONE)       acc_err = 1'b1;
            if (bus_size != SZ_BYTE)      acc_err = 1'b1;
            if (bus_rd && bus_wr)         acc_err = 1'b1;
            if (bus_wr && (sel.kind == K_PIN || (bus_wdata & ~mask) != '0))
                acc_err = 1'b1;
        end
    end

    assign wr_ok = bus_wr && !bus_rd && !acc_err;

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        gpio_port_regs #(.PORT_IDX(g)) i_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_out  (wr_ok && sel.kind == K_OUT  && sel.port == PIDX_W'(g)),
            .we_mode (wr_ok && sel.kind == K_MODE && sel.port == PIDX_W'(g)),
            .we_dir  (wr_ok && sel.kind == K_DIR  && sel.port == PIDX_W'(g)),
            .wdata   (bus_wdata),
            .out_q   (out_arr[g]),
            .mode_q  (mode_arr[g]),
            .dir_q   (dir_arr[g])
        );
        assign port_out[g*BYTE_W +: BYTE_W] = out_arr[g];
        assign port_oe [g*BYTE_W +: BYTE_W] = dir_arr[g];
    end

    // Hold the two pin-function select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_a_q <= 8'h00;
            sel_b_q <= 8'h0F;
        end else if (wr_ok) begin
            if (sel.kind == K_SELA) sel_a_q <= bus_wdata;
            if (sel.kind == K_SELB) sel_b_q <= bus_wdata;
        end
    end

    // Select the register addressed by the current read.
    always_comb begin
        unique case (sel.kind)
            K_OUT:   rd_val = out_arr[sel.port];
            K_MODE:  rd_val = mode_arr[sel.port];
            K_DIR:   rd_val = dir_arr[sel.port];
            K_PIN:   rd_val = pin_sync[sel.port*BYTE_W +: BYTE_W];
            K_SELA:  rd_val = sel_a_q;
            K_SELB:  rd_val = sel_b_q;
            default: rd_val = '0;
        endcase
    end

    // Register the response one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= (bus_rd && !acc_err) ? rd_val : '0;
            bus_err   <= acc_err;
        end
    end

    // R9
    err_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_rd || bus_wr));
    // R9
    err_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_rdata == '0);
    // R3
    bad_offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel.kind == K_NONE) |=> bus_err && $stable(port_out) && $stable(port_oe));
    // R4
    bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && bus_size != SZ_BYTE) |=> bus_err && $stable(port_out) && $stable(port_oe));
    // R10
    pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(port_out) && $stable(port_oe));
    // R11
    rd_wr_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_wr) |=> bus_err && $stable(port_out) && $stable(port_oe));
    // R8
    sel_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a_q[7:2] == '0) && (sel_b_q[7:4] == '0));

endmodule

// File: tb/test_gpio_regbank.sv
module test_gpio_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_size = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_err;
    logic [31:0] port_in = '0;
    logic [31:0] port_out;
    logic [31:0] port_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] m_out [4];
    logic [7:0] m_mode [4];
    logic [7:0] m_dir [4];
    logic [7:0] m_sa;
    logic [7:0] m_sb;

    gpio_regbank i_gpio_regbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .port_in   (port_in),
        .port_out  (port_out),
        .port_oe   (port_oe)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Kind codes: 0 none, 1 out, 2 mode, 3 dir, 4 pin, 5 sel A, 6 sel B
    function automatic int bkind(input logic [7:0] a);
        case (a)
            8'h00, 8'h01, 8'h04, 8'h05: return 1;
            8'h20, 8'h21, 8'h24, 8'h25: return 2;
            8'h60, 8'h61, 8'h64, 8'h65: return 3;
            8'h80, 8'h81, 8'h84, 8'h85: return 4;
            8'h44: return 5;
            8'h48: return 6;
            default: return 0;
        endcase
    endfunction

    function automatic int bport(input logic [7:0] a);
        case (a[2:0])
            3'd0: return 0;
            3'd1: return 1;
            3'd4: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [7:0] bmask(input int k, input int p);
        case (k)
            1, 3: return (p == 3) ? 8'h03 : 8'hFF;
            2: return (p == 3) ? 8'h03 : ((p < 2) ? 8'h01 : 8'hFF);
            5: return 8'h03;
            6: return 8'h0F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] legal_addr(input int i);
        logic [7:0] base [5] = '{8'h00, 8'h20, 8'h60, 8'h80, 8'h40};
        logic [7:0] lo [4] = '{8'h00, 8'h01, 8'h04, 8'h05};
        if (i >= 16) return (i == 16) ? 8'h44 : 8'h48;
        return base[i / 4] | lo[i % 4];
    endfunction

    // Expected response and model update for one request.
    task automatic model_op(input logic rd, input logic wr, input logic [7:0] a,
                            input logic [1:0] sz, input logic [7:0] d,
                            output logic e_err, output logic [7:0] e_rd);
        int k = bkind(a);
        int p = bport(a);
        e_err = (k == 0) || (sz != 0) || (rd && wr) ||
                (wr && (k == 4 || (d & ~bmask(k, p)) != 0));
        e_rd = 8'h00;
        if (!e_err && rd) begin
            case (k)
                1: e_rd = m_out[p];
                2: e_rd = m_mode[p];
                3: e_rd = m_dir[p];
                4: e_rd = port_in[p*8 +: 8];
                5: e_rd = m_sa;
                default: e_rd = m_sb;
            endcase
        end
        if (!e_err && wr) begin
            case (k)
                1: m_out[p] = d;
                2: m_mode[p] = d;
                3: m_dir[p] = d;
                5: m_sa = d;
                default: m_sb = d;
            endcase
        end
    endtask

    task automatic bus_op(input logic rd, input logic wr, input logic [7:0] a,
                          input logic [1:0] sz, input logic [7:0] d,
                          output logic [7:0] got_rd, output logic got_err);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        got_rd = bus_rdata; got_err = bus_err;
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic op_chk(input string req, input logic rd, input logic wr,
                          input logic [7:0] a, input logic [1:0] sz, input logic [7:0] d);
        logic [7:0] g_rd, e_rd;
        logic g_err, e_err;
        model_op(rd, wr, a, sz, d, e_err, e_rd);
        bus_op(rd, wr, a, sz, d, g_rd, g_err);
        chk({req, " err"}, 32'(g_err), 32'(e_err));
        chk({req, " rdata"}, 32'(g_rd), 32'(e_rd));
        chk("R10 port_out", port_out, {m_out[3], m_out[2], m_out[1], m_out[0]});
        chk("R10 port_oe", port_oe, {m_dir[3], m_dir[2], m_dir[1], m_dir[0]});
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        port_in = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_out[i] = 8'h00; m_mode[i] = (i == 2) ? 8'hFF : 8'h00; m_dir[i] = 8'h00;
        end
        m_sa = 8'h00; m_sb = 8'h0F;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the pins and through reads
        chk("R1 port_out", port_out, 32'h0);
        chk("R1 port_oe", port_oe, 32'h0);
        chk("R9 idle err", 32'(bus_err), 32'h0);
        for (int i = 0; i < 18; i++) op_chk("R1 R2 reset read", 1, 0, legal_addr(i), 2'd0, 8'h00);

        // R2 R10 directed writes with readback
        op_chk("R2 write out0", 0, 1, 8'h00, 2'd0, 8'hA5);
        op_chk("R2 read out0", 1, 0, 8'h00, 2'd0, 8'h00);
        op_chk("R10 write dir1", 0, 1, 8'h61, 2'd0, 8'h3C);
        op_chk("R2 write mode2", 0, 1, 8'h24, 2'd0, 8'h5A);
        op_chk("R2 read mode2", 1, 0, 8'h24, 2'd0, 8'h00);
        // R5 port 3 masks
        op_chk("R5 out3 bad", 0, 1, 8'h05, 2'd0, 8'h04);
        op_chk("R5 out3 ok", 0, 1, 8'h05, 2'd0, 8'h03);
        op_chk("R5 dir3 bad", 0, 1, 8'h65, 2'd0, 8'h80);
        op_chk("R5 mode3 bad", 0, 1, 8'h25, 2'd0, 8'hFC);
        op_chk("R5 read out3", 1, 0, 8'h05, 2'd0, 8'h00);
        // R6 ports 0/1 mode masks
        op_chk("R6 mode0 bad", 0, 1, 8'h20, 2'd0, 8'h02);
        op_chk("R6 mode1 ok", 0, 1, 8'h21, 2'd0, 8'h01);
        op_chk("R6 read mode0", 1, 0, 8'h20, 2'd0, 8'h00);
        // R7 pin registers
        op_chk("R7 pin write", 0, 1, 8'h80, 2'd0, 8'h00);
        set_pins(32'h11223344);
        op_chk("R7 pin0", 1, 0, 8'h80, 2'd0, 8'h00);
        op_chk("R7 pin3", 1, 0, 8'h85, 2'd0, 8'h00);
        // R8 select masks
        op_chk("R8 selA bad", 0, 1, 8'h44, 2'd0, 8'h04);
        op_chk("R8 selA ok", 0, 1, 8'h44, 2'd0, 8'h02);
        op_chk("R8 selB bad", 0, 1, 8'h48, 2'd0, 8'h10);
        op_chk("R8 selB ok", 0, 1, 8'h48, 2'd0, 8'h0A);
        op_chk("R8 selB read", 1, 0, 8'h48, 2'd0, 8'h00);
        // R3 unmapped offsets
        op_chk("R3 bad write", 0, 1, 8'h02, 2'd0, 8'h00);
        op_chk("R3 bad read", 1, 0, 8'h45, 2'd0, 8'h00);
        // R4 size codes
        op_chk("R4 size2 write", 0, 1, 8'h01, 2'd1, 8'h77);
        op_chk("R4 size4 read", 1, 0, 8'h00, 2'd2, 8'h00);
        // R11 read and write together
        op_chk("R11 clash", 1, 1, 8'h04, 2'd0, 8'h99);
        // R9 error lasts one cycle
        @(negedge clk);
        chk("R9 err pulse width", 32'(bus_err), 32'h0);

        // Random mix checked against the model
        for (int n = 0; n < 600; n++) begin
            logic [7:0] a, d;
            logic [1:0] sz;
            logic rd, wr;
            int r = $urandom % 20;
            a = ($urandom % 4 == 0) ? 8'($urandom) : legal_addr($urandom % 18);
            d = ($urandom % 2 == 0) ? (8'($urandom) & 8'h03) : 8'($urandom);
            sz = ($urandom % 10 == 0) ? 2'($urandom) : 2'd0;
            rd = (r < 9) || (r == 19);
            wr = (r >= 9);
            if (n % 50 == 0) set_pins($urandom);
            op_chk("R2 R3 R4 R5 R6 R7 R8 R9 R11 random", rd, wr, a, sz, d);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule